// File: doc/BRIEF.md
# Four-Bit Function-Selectable ALU Slice

This block is a combinational arithmetic and logic slice that works on two four-bit active-high words. A four-bit select code together with a mode bit picks one of 32 operations. With the mode bit high, the slice applies one of the sixteen two-input Boolean functions to each bit position on its own, and no carries are used. With the mode bit low, the slice forms a four-bit sum from two select-controlled operand terms plus a carry input. Inside a slice the carries come from flat lookahead equations, not from a ripple chain.

Each slice also exports a group propagate flag, a group generate flag, a carry output and an all-ones flag. The flags are there so that slices can be cascaded, either by feeding each carry output into the next carry input or through an external lookahead unit. The top level is a test wrapper. It chains a parameterised number of slices in ripple fashion and also combines their group flags into word-level flags. The results are registered so the slice can be exercised synchronously.

Top module: `alu_chain_top`

## Requirements
- R1: While rst_n is low, every registered output is 0. Otherwise each output shows, one clock edge later, the function of the inputs sampled at that edge.
- R2: With logic_mode_i=1, result bit i is ~(X_i ^ Y_i). It depends only on a_i[i], b_i[i] and sel_i, and carry_i has no effect on it. Over the 16 select codes, all 16 two-input truth tables are produced.
- R3: The logic-mode encodings are: sel 0000 gives ~A, 1111 gives A, 0011 gives all zeros, 1100 gives all ones, 0110 gives A^B and 1001 gives ~(A^B).
- R4: The arithmetic-mode encodings (logic_mode_i=0) are: sel 1001 gives A+B, 0110 gives A-B-1, 1100 gives A+A, 0000 gives A and 1111 gives A-1. All are taken modulo 2^W, and carry_i=1 adds exactly one to each.
- R5: In arithmetic mode the result is (X+Y+carry_i) mod 2^W. The operand terms are X_i = A_i | (B_i & sel[0]) | (~B_i & sel[1]) and Y_i = (A_i & B_i & sel[3]) | (A_i & ~B_i & sel[2]).
- R6: carry_o is bit W of X+Y+carry_i in either mode. For sel 0110 with carry_i=1 it is 1 exactly when A>=B, so 1 means no borrow.
- R7: gen_o is 1 exactly when X+Y >= 2^W. prop_o is 1 exactly when X+Y = 2^W-1. Neither flag depends on carry_i or on the mode bit, and the two flags are never 1 together.
- R8: For sel 0110 in arithmetic mode, prop_o is 1 exactly when A==B and gen_o is 1 exactly when A>B.
- R9: allones_o is 1 exactly when every result bit is 1. For sel 0110 in arithmetic mode with carry_i=0, this means A==B.
- R10: SLICES four-bit slices chained through their carries give the same W-bit results and flags as a single W-bit operation. The rippled carry also equals the carry formed from the word-level group flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Active-low synchronous reset |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| sel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_i | input | 1 | Carry into the least significant slice (1 = carry) |
| res_o | output | W | Registered result |
| carry_o | output | 1 | Registered carry out of the most significant slice |
| prop_o | output | 1 | Registered word group propagate |
| gen_o | output | 1 | Registered word group generate |
| allones_o | output | 1 | Registered all-result-bits-one flag |

## Verification
The bench builds two copies of the block. A single slice (SLICES=1) is small enough to check exhaustively: every select code, mode, carry input and operand pair is compared against a reference model, and this also confirms that all sixteen logic truth tables are reachable. A default four-slice, 16-bit instance is checked with a vector table of chosen words and with a pseudo-random add and subtract sweep. That sweep covers carries crossing slice boundaries and the agreement between the ripple carry and the carry formed from the combined group flags.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int SLICE_W = 4;
    localparam int SEL_W   = 4;
    typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
    import alu_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  sel_t         sel,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // term from the low select pair
        assign x_o[i] = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
        // term from the high select pair
        assign y_o[i] = (a[i] & b[i] & sel[3]) | (a[i] & ~b[i] & sel[2]);
    end
endmodule

// File: rtl/alu_slice4.sv
module alu_slice4
    import alu_pkg::*;
(
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  sel_t               sel,
    input  logic               logic_mode,
    input  logic               cin,
    output logic [SLICE_W-1:0] res,
    output logic               cout,
    output logic               prop,
    output logic               gen,
    output logic               allones
);
    logic [SLICE_W-1:0] x_t, y_t, half_t, gen_t;
    logic [SLICE_W:0]   carry_t;

    alu_bit_terms #(.W(SLICE_W)) u_terms (
        .a   (a),
        .b   (b),
        .sel (sel),
        .x_o (x_t),
        .y_o (y_t)
    );

    assign half_t = x_t ^ y_t;
    assign gen_t  = x_t & y_t;

    // flat lookahead: each carry is a sum of products over lower bits
    always_comb begin
        for (int i = 0; i <= SLICE_W; i++) begin
            logic run;
            logic acc;
            run = 1'b1;
            acc = 1'b0;
            for (int j = i - 1; j >= 0; j--) begin
                acc = acc | (run & gen_t[j]);
                run = run & half_t[j];
            end
            carry_t[i] = acc | (run & cin);
        end
    end

    always_comb begin
        logic run;
        gen = 1'b0;
        run = 1'b1;
        for (int j = SLICE_W - 1; j >= 0; j--) begin
            gen = gen | (run & gen_t[j]);
            run = run & half_t[j];
        end
    end

    assign prop    = &half_t;
    assign cout    = carry_t[SLICE_W];
    assign res     = logic_mode ? ~half_t : (half_t ^ carry_t[SLICE_W-1:0]);
    assign allones = &res;
endmodule

// File: rtl/alu_group_combine.sv
module alu_group_combine #(
    parameter int N = 4
) (
    input  logic [N-1:0] prop_i,
    input  logic [N-1:0] gen_i,
    input  logic         cin,
    output logic         word_prop,
    output logic         word_gen,
    output logic         word_carry
);
    always_comb begin
        logic run;
        word_gen = 1'b0;
        run      = 1'b1;
        for (int j = N - 1; j >= 0; j--) begin
            word_gen = word_gen | (run & gen_i[j]);
            run      = run & prop_i[j];
        end
        word_prop  = run;
        word_carry = word_gen | (word_prop & cin);
    end
endmodule

// File: rtl/alu_chain_top.sv
module alu_chain_top
    import alu_pkg::*;
#(
    parameter int SLICES = 4,
    localparam int W = SLICES * SLICE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   sel_i,
    input  logic         logic_mode_i,
    input  logic         carry_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         prop_o,
    output logic         gen_o,
    output logic         allones_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         carry;
        logic         prop;
        logic         gen;
        logic         allones;
    } out_t;

    out_t out_d, out_q;

    logic [SLICES:0]   ripple_c;
    logic [SLICES-1:0] sl_prop, sl_gen, sl_ones;
    logic [W-1:0]      res_w;
    logic              word_prop, word_gen, word_carry;

    assign ripple_c[0] = carry_i;

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        alu_slice4 u_slice (
            .a          (a_i[s*SLICE_W +: SLICE_W]),
            .b          (b_i[s*SLICE_W +: SLICE_W]),
            .sel        (sel_i),
            .logic_mode (logic_mode_i),
            .cin        (ripple_c[s]),
            .res        (res_w[s*SLICE_W +: SLICE_W]),
            .cout       (ripple_c[s+1]),
            .prop       (sl_prop[s]),
            .gen        (sl_gen[s]),
            .allones    (sl_ones[s])
        );
    end

    alu_group_combine #(.N(SLICES)) u_group (
        .prop_i     (sl_prop),
        .gen_i      (sl_gen),
        .cin        (carry_i),
        .word_prop  (word_prop),
        .word_gen   (word_gen),
        .word_carry (word_carry)
    );

    always_comb begin
        out_d         = out_q;
        out_d.res     = res_w;
        out_d.carry   = ripple_c[SLICES];
        out_d.prop    = word_prop;
        out_d.gen     = word_gen;
        out_d.allones = &sl_ones;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o     = out_q.res;
    assign carry_o   = out_q.carry;
    assign prop_o    = out_q.prop;
    assign gen_o     = out_q.gen;
    assign allones_o = out_q.allones;

    logic sub_nocin;
    assign sub_nocin = (sel_i == 4'b0110) && !logic_mode_i && !carry_i;

    // R10
    ripple_lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_carry == ripple_c[SLICES]);

    // R7
    prop_gen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.prop && out_q.gen));

    // R6
    carry_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_q.carry == (out_q.gen | (out_q.prop & $past(carry_i)))));

    // R8
    sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sub_nocin)) |-> (out_q.allones == out_q.prop));

    // R3
    logic_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(logic_mode_i) && ($past(sel_i) == 4'b1111))
        |-> (out_q.res == $past(a_i)));
endmodule

// File: tb/alu_chain_top_tb.sv
module alu_chain_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // 16-bit chained instance
    logic [15:0] a16 = '0, b16 = '0, r16;
    logic [3:0]  s16 = '0;
    logic        m16 = 1'b0, c16 = 1'b0;
    logic        co16, p16, g16, e16;

    // single slice instance
    logic [3:0] a4 = '0, b4 = '0, r4, s4 = '0;
    logic       m4 = 1'b0, c4 = 1'b0;
    logic       co4, p4, g4, e4;

    alu_chain_top #(.SLICES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a16), .b_i(b16), .sel_i(s16),
        .logic_mode_i(m16), .carry_i(c16), .res_o(r16), .carry_o(co16),
        .prop_o(p16), .gen_o(g16), .allones_o(e16)
    );

    alu_chain_top #(.SLICES(1)) u_one (
        .clk(clk), .rst_n(rst_n), .a_i(a4), .b_i(b4), .sel_i(s4),
        .logic_mode_i(m4), .carry_i(c4), .res_o(r4), .carry_o(co4),
        .prop_o(p4), .gen_o(g4), .allones_o(e4)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference: {cout, gen, prop, ones, res[15:0]}
    function automatic logic [19:0] ref_calc(input int w, input logic [15:0] a,
        input logic [15:0] b, input logic [3:0] s, input logic m, input logic cin);
        logic [16:0] mask, x, y, nocin, sum, res;
        mask  = (17'd1 << w) - 17'd1;
        x     = {1'b0, (a | (b & {16{s[0]}}) | (~b & {16{s[1]}}))} & mask;
        y     = {1'b0, ((a & b & {16{s[3]}}) | (a & ~b & {16{s[2]}}))} & mask;
        nocin = x + y;
        sum   = nocin + {16'd0, cin};
        res   = m ? (~(x ^ y) & mask) : (sum & mask);
        return {sum[w], nocin[w], (nocin == mask), (res == mask), res[15:0]};
    endfunction

    // {sel, mode, cin, a, b, expected res, expected carry}
    localparam logic [54:0] VEC [0:13] = '{
        {4'b1001, 1'b0, 1'b0, 16'h1234, 16'h4321, 16'h5555, 1'b0},
        {4'b1001, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 1'b1},
        {4'b0110, 1'b0, 1'b1, 16'h0005, 16'h0003, 16'h0002, 1'b1},
        {4'b0110, 1'b0, 1'b1, 16'h0003, 16'h0005, 16'hFFFE, 1'b0},
        {4'b0110, 1'b0, 1'b0, 16'h0007, 16'h0007, 16'hFFFF, 1'b0},
        {4'b1100, 1'b0, 1'b0, 16'h8001, 16'h0000, 16'h0002, 1'b1},
        {4'b0000, 1'b0, 1'b0, 16'hABCD, 16'h0000, 16'hABCD, 1'b0},
        {4'b1111, 1'b0, 1'b0, 16'h0010, 16'h0000, 16'h000F, 1'b1},
        {4'b0110, 1'b1, 1'b0, 16'hF0F0, 16'hFF00, 16'h0FF0, 1'b0},
        {4'b0000, 1'b1, 1'b0, 16'h1234, 16'h0000, 16'hEDCB, 1'b0},
        {4'b0011, 1'b1, 1'b1, 16'h5555, 16'hAAAA, 16'h0000, 1'b1},
        {4'b1100, 1'b1, 1'b0, 16'h8000, 16'h0000, 16'hFFFF, 1'b1},
        {4'b1111, 1'b1, 1'b0, 16'h5A5A, 16'h0000, 16'h5A5A, 1'b1},
        {4'b1001, 1'b1, 1'b0, 16'hF0F0, 16'hFF00, 16'hF00F, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] exp;
        logic [15:0] lfsr_a, lfsr_b;
        logic [15:0] reach;
        logic [3:0]  tt [16];

        // R1: reset holds outputs at zero despite active inputs
        a16 = 16'hFFFF; b16 = 16'h0001; s16 = 4'b1001; c16 = 1'b1;
        a4 = 4'hF; s4 = 4'b1100; m4 = 1'b1;
        repeat (3) @(negedge clk);
        check({r16, co16, p16, g16, e16} == '0, "R1 reset chain outputs",
              {r16, co16, p16, g16, e16}, 0);
        check({r4, co4, p4, g4, e4} == '0, "R1 reset slice outputs",
              {r4, co4, p4, g4, e4}, 0);
        rst_n = 1'b1;

        // table of directed 16-bit vectors (R3, R4, R6, R10)
        for (int k = 0; k < 14; k++) begin
            {s16, m16, c16, a16, b16} = VEC[k][54:17];
            @(negedge clk);
            check(r16 == VEC[k][16:1], m16 ? "R3 logic encoding" : "R4 arith encoding",
                  r16, VEC[k][16:1]);
            check(co16 == VEC[k][0], "R6 carry out", co16, VEC[k][0]);
        end

        // exhaustive single slice (R2, R5, R6, R7, R8, R9)
        for (int s = 0; s < 16; s++) tt[s] = '0;
        for (int s = 0; s < 16; s++)
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 16; a++)
                        for (int b = 0; b < 16; b++) begin
                            s4 = 4'(s); m4 = 1'(m); c4 = 1'(c); a4 = 4'(a); b4 = 4'(b);
                            @(negedge clk);
                            exp = ref_calc(4, {12'd0, a4}, {12'd0, b4}, s4, m4, c4);
                            check({co4, g4, p4, e4, r4} == {exp[19:16], exp[3:0]},
                                  m ? "R2 logic slice" : "R5 R6 R7 R9 arith slice",
                                  {co4, g4, p4, e4, r4}, {exp[19:16], exp[3:0]});
                            if (m == 1 && a < 2 && b < 2) tt[s][{a[0], b[0]}] = r4[0];
                            if (s == 6 && m == 0) begin
                                check(p4 == (a == b) && g4 == (a > b), "R8 subtract flags",
                                      {p4, g4}, {(a == b), (a > b)});
                                if (c == 1)
                                    check(co4 == (a >= b), "R6 no-borrow carry", co4, (a >= b));
                                else
                                    check(e4 == (a == b), "R9 equality flag", e4, (a == b));
                            end
                        end
        reach = '0;
        for (int s = 0; s < 16; s++) reach[tt[s]] = 1'b1;
        check(reach == 16'hFFFF, "R2 all truth tables reached", reach, 16'hFFFF);

        // chained pseudo-random add and subtract (R10)
        lfsr_a = 16'hACE1; lfsr_b = 16'h1D2B;
        for (int k = 0; k < 1500; k++) begin
            lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
            lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
            a16 = lfsr_a;
            b16 = (k % 7 == 0) ? lfsr_a : lfsr_b;
            s16 = k[0] ? 4'b0110 : 4'b1001;
            m16 = 1'b0;
            c16 = k[1];
            @(negedge clk);
            exp = ref_calc(16, a16, b16, s16, m16, c16);
            check({co16, g16, p16, e16, r16} == exp, "R10 chained word",
                  {co16, g16, p16, e16, r16}, exp);
        end

        // R1: one-cycle latency, output follows the new input after a single edge
        s16 = 4'b1111; m16 = 1'b1; a16 = 16'h3C3C; c16 = 1'b0;
        @(negedge clk);
        check(r16 == 16'h3C3C, "R1 one-cycle latency", r16, 16'h3C3C);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule